// File: doc/BRIEF.md
# Playback Sample Count Interrupt Generator

This block sits beside a playback data mover and keeps count of how many bytes have gone to the playback sink since the last interrupt. Software programs a 16-bit sample count as a high byte and a low byte. The block turns that count into a byte target by shifting it left by an amount that follows from the playback format byte: sample width and channel count. For every transfer, the block states the largest chunk the mover may send next. It clips that chunk so that a transfer ends exactly on the target. When a chunk meets the target exactly, the block raises its status and playback-interrupt flags and restarts its byte total from zero.

A small state machine with three states tracks playback. ST_STOP means playback is idle. ST_RUN means playback is active and chunks are counted. ST_FAULT means playback was requested with a format code the block cannot play. The transitions are as follows. Start goes from ST_STOP to ST_RUN when enable is high and the format is valid, and it clears the byte total. Halt goes from ST_RUN to ST_STOP when enable drops. Reject goes from ST_STOP or ST_RUN to ST_FAULT when the decoded format is invalid while enable is high. Recover goes from ST_FAULT to ST_STOP when enable drops. The interrupt flags are sticky until the register interface pulses a clear.

Top module: `play_count_irq`

## Requirements
- R1: After reset the block is in ST_STOP. The outputs `play_active`, `irq_status` and `pb_irq_flag` are 0, and `chunk_limit` is 0.
- R2: The format code is `fmt_byte[7:5]`, masked to bits 6:5 when `ext_mode` is 0. Bit 4 selects stereo. Codes 0 (unsigned 8-bit), 1 and 3 (companded 8-bit) give a shift equal to the stereo bit. Codes 2 and 6 (16-bit little and big endian) give a shift of 1 plus the stereo bit.
- R3: In ST_RUN with `count_en` high, `chunk_limit` equals the smaller of `sink_space` and the remaining byte count. The remaining count is ({count_hi,count_lo} << shift) minus the byte total.
- R4: In ST_RUN with `count_en` low, `chunk_limit` equals `sink_space`.
- R5: An accepted chunk whose length equals a positive remaining count, with `count_en` high, sets `irq_status` and `pb_irq_flag` on the next edge and clears the byte total to 0.
- R6: Any other accepted nonzero chunk in ST_RUN adds its length to the byte total. This holds whether or not `count_en` is high.
- R7: A zero-length chunk does not change the byte total. With `count_en` high, a chunk arriving when the remaining count is zero or negative also does not change it. In that case `chunk_limit` is 0.
- R8: The Start transition clears the byte total to 0.
- R9: Codes 4, 5 and 7 (reachable only with `ext_mode` high) are invalid. While enable is high they put the block in ST_FAULT. In ST_FAULT, `play_active` is 0, `chunk_limit` is 0, and chunks are ignored.
- R10: `irq_status` and `pb_irq_flag` hold until a `flag_clr` pulse. A completion in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| play_en | input | 1 | Playback enable |
| count_en | input | 1 | Sample-count interrupt enable |
| ext_mode | input | 1 | Extended mode: widens the format code to 3 bits |
| fmt_byte | input | 8 | Playback format byte |
| count_hi | input | 8 | Sample count, upper byte |
| count_lo | input | 8 | Sample count, lower byte |
| sink_space | input | 19 | Bytes the sink can take now |
| chunk_valid | input | 1 | A chunk is transferred this cycle |
| chunk_len | input | 19 | Byte length of the chunk |
| flag_clr | input | 1 | Clear pulse for both interrupt flags |
| chunk_limit | output | 19 | Largest chunk allowed next |
| play_active | output | 1 | Block is in ST_RUN |
| irq_status | output | 1 | Status interrupt bit |
| pb_irq_flag | output | 1 | Playback-interrupt flag |

## Verification
Every combination of the three format bits, the stereo bit and the extended-mode bit is started from ST_STOP. The resulting limit, checked against a small count and a large sink, shows whether each code picks the right shift or lands in ST_FAULT. A single 16-bit stereo run then uses partial, zero, exact and oversize sequences to separate three behaviours: accumulation, the terminal match with its flag setting, and the no-update rule for a negative remaining count. Toggling `count_en` and `play_en` in the middle of that run separates the unlimited mode from the clearing on restart. A clear that coincides with a completion shows which one has priority.

// File: rtl/play_count_irq_pkg.sv
package play_count_irq_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } play_state_e;

    localparam logic [2:0] FMT_U8     = 3'd0;
    localparam logic [2:0] FMT_ULAW   = 3'd1;
    localparam logic [2:0] FMT_S16LE  = 3'd2;
    localparam logic [2:0] FMT_ALAW   = 3'd3;
    localparam logic [2:0] FMT_RSV4   = 3'd4;
    localparam logic [2:0] FMT_ADPCM  = 3'd5;
    localparam logic [2:0] FMT_S16BE  = 3'd6;
    localparam logic [2:0] FMT_RSV7   = 3'd7;
endpackage

// File: rtl/pci_fmt_decode.sv
module pci_fmt_decode
    import play_count_irq_pkg::*;
(
    input  logic [7:0] fmt_byte,
    input  logic       ext_mode,
    output logic [1:0] shift,
    output logic       fmt_ok
);
    logic [2:0] code;
    logic       stereo;

    always_comb begin
        stereo = fmt_byte[4];
        code   = fmt_byte[7:5] & (ext_mode ? 3'b111 : 3'b011);
        shift  = 2'd0;
        fmt_ok = 1'b1;
        unique case (code)
            FMT_U8, FMT_ULAW, FMT_ALAW: shift = {1'b0, stereo};
            FMT_S16LE, FMT_S16BE:       shift = stereo ? 2'd2 : 2'd1;
            FMT_RSV4, FMT_ADPCM, FMT_RSV7: begin
                shift  = 2'd0;
                fmt_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pci_play_ctrl.sv
module pci_play_ctrl
    import play_count_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic play_en,
    input  logic fmt_ok,
    output logic running,
    output logic start
);
    play_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (play_en && fmt_ok)  state_d = ST_RUN;
                else if (play_en)       state_d = ST_FAULT;
            end
            ST_RUN: begin
                if (!play_en)           state_d = ST_STOP;
                else if (!fmt_ok)       state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (!play_en)           state_d = ST_STOP;
            end
            default:                    state_d = ST_STOP;
        endcase
    end

    always_comb begin
        running = (state_q == ST_RUN);
        start   = (state_q == ST_STOP) && (state_d == ST_RUN);
    end
endmodule

// File: rtl/pci_count_track.sv
module pci_count_track #(
    parameter int CNT_W = 16,
    parameter int LEN_W = CNT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             running,
    input  logic             count_en,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       shift,
    input  logic [LEN_W-1:0] sink_space,
    input  logic             chunk_valid,
    input  logic [LEN_W-1:0] chunk_len,
    output logic [LEN_W-1:0] chunk_limit,
    output logic [LEN_W-1:0] total,
    output logic             fire
);
    localparam int REM_W = LEN_W + 1;

    logic [LEN_W-1:0]        total_q;
    logic [LEN_W-1:0]        target;
    logic signed [REM_W-1:0] remaining;
    logic                    rem_pos;
    logic                    accept;
    logic                    len_nz;

    always_comb begin
        target    = LEN_W'(count) << shift;
        remaining = $signed({1'b0, target}) - $signed({1'b0, total_q});
        rem_pos   = (remaining > 0);
        accept    = running && chunk_valid;
        len_nz    = (chunk_len != '0);
        fire      = accept && len_nz && count_en && rem_pos &&
                    ({1'b0, chunk_len} == REM_W'(remaining));
    end

    always_comb begin
        if (!running)
            chunk_limit = '0;
        else if (!count_en)
            chunk_limit = sink_space;
        else if (!rem_pos)
            chunk_limit = '0;
        else if (remaining[LEN_W-1:0] < sink_space)
            chunk_limit = remaining[LEN_W-1:0];
        else
            chunk_limit = sink_space;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            total_q <= '0;
        end else if (start) begin
            total_q <= '0;
        end else if (accept && len_nz) begin
            if (!count_en)
                total_q <= total_q + chunk_len;
            else if (fire)
                total_q <= '0;
            else if (rem_pos)
                total_q <= total_q + chunk_len;
        end
    end

    assign total = total_q;
endmodule

// File: rtl/pci_irq_flags.sv
module pci_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic int_bit,
    output logic pb_flag
);
    logic int_q, pb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= 1'b0;
            pb_q  <= 1'b0;
        end else if (set) begin
            int_q <= 1'b1;
            pb_q  <= 1'b1;
        end else if (clr) begin
            int_q <= 1'b0;
            pb_q  <= 1'b0;
        end
    end

    assign int_bit = int_q;
    assign pb_flag = pb_q;
endmodule

// File: rtl/play_count_irq.sv
module play_count_irq #(
    parameter int CNT_W = 16,
    parameter int LEN_W = CNT_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             play_en,
    input  logic             count_en,
    input  logic             ext_mode,
    input  logic [7:0]       fmt_byte,
    input  logic [7:0]       count_hi,
    input  logic [7:0]       count_lo,
    input  logic [LEN_W-1:0] sink_space,
    input  logic             chunk_valid,
    input  logic [LEN_W-1:0] chunk_len,
    input  logic             flag_clr,
    output logic [LEN_W-1:0] chunk_limit,
    output logic             play_active,
    output logic             irq_status,
    output logic             pb_irq_flag
);
    logic [1:0]       shift;
    logic             fmt_ok;
    logic             running;
    logic             start;
    logic             fire;
    logic [LEN_W-1:0] total;
    logic [CNT_W-1:0] count;

    assign count = CNT_W'({count_hi, count_lo});

    pci_fmt_decode u_dec (
        .fmt_byte (fmt_byte),
        .ext_mode (ext_mode),
        .shift    (shift),
        .fmt_ok   (fmt_ok)
    );

    pci_play_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .play_en (play_en),
        .fmt_ok  (fmt_ok),
        .running (running),
        .start   (start)
    );

    pci_count_track #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .running     (running),
        .count_en    (count_en),
        .count       (count),
        .shift       (shift),
        .sink_space  (sink_space),
        .chunk_valid (chunk_valid),
        .chunk_len   (chunk_len),
        .chunk_limit (chunk_limit),
        .total       (total),
        .fire        (fire)
    );

    pci_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (fire),
        .clr     (flag_clr),
        .int_bit (irq_status),
        .pb_flag (pb_irq_flag)
    );

    assign play_active = running;
endmodule

// File: rtl/play_count_irq_chk.sv
module play_count_irq_chk #(
    parameter int LEN_W = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fire,
    input logic             flag_clr,
    input logic             irq_status,
    input logic             pb_irq_flag,
    input logic             play_active,
    input logic             count_en,
    input logic             chunk_valid,
    input logic [LEN_W-1:0] chunk_len,
    input logic [LEN_W-1:0] chunk_limit,
    input logic [LEN_W-1:0] sink_space,
    input logic [LEN_W-1:0] total
);
    a_r5_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (irq_status && pb_irq_flag && total == '0));

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !flag_clr) |=> irq_status);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fire) |=> (!irq_status && !pb_irq_flag));

    a_r9_idle_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !play_active |-> (chunk_limit == '0));

    a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (play_active && count_en) |-> (chunk_limit <= sink_space));

    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_valid && chunk_len == '0 && play_active) |=> $stable(total));

    a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_active) |-> (total == '0));
endmodule

bind play_count_irq play_count_irq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .flag_clr    (flag_clr),
    .irq_status  (irq_status),
    .pb_irq_flag (pb_irq_flag),
    .play_active (play_active),
    .count_en    (count_en),
    .chunk_valid (chunk_valid),
    .chunk_len   (chunk_len),
    .chunk_limit (chunk_limit),
    .sink_space  (sink_space),
    .total       (total)
);

// File: tb/play_count_irq_tb_top.sv
module play_count_irq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          play_en = 1'b0, count_en = 1'b0, ext_mode = 1'b0;
    logic [7:0]    fmt_byte = '0, count_hi = '0, count_lo = '0;
    logic [LW-1:0] sink_space = '0, chunk_len = '0;
    logic          chunk_valid = 1'b0, flag_clr = 1'b0;
    logic [LW-1:0] chunk_limit;
    logic          play_active, irq_status, pb_irq_flag;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    play_count_irq dut_i (
        .clk(clk), .rst_n(rst_n), .play_en(play_en), .count_en(count_en),
        .ext_mode(ext_mode), .fmt_byte(fmt_byte), .count_hi(count_hi),
        .count_lo(count_lo), .sink_space(sink_space), .chunk_valid(chunk_valid),
        .chunk_len(chunk_len), .flag_clr(flag_clr), .chunk_limit(chunk_limit),
        .play_active(play_active), .irq_status(irq_status),
        .pb_irq_flag(pb_irq_flag)
    );

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(int len);
        chunk_valid = 1'b1;
        chunk_len   = LW'(len);
        step();
        chunk_valid = 1'b0;
        chunk_len   = '0;
    endtask

    task automatic restart();
        play_en = 1'b0;
        step();
        play_en = 1'b1;
        step();
    endtask

    initial begin
        int wd;
        wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R1: reset state
        chk("R1 active", int'(play_active), 0);
        chk("R1 limit", int'(chunk_limit), 0);
        chk("R1 int", int'(irq_status), 0);
        chk("R1 pb", int'(pb_irq_flag), 0);
        rst_n = 1'b1;
        step();
        chk("R1 active after release", int'(play_active), 0);

        // R2/R9 sweep: count 5, large sink
        count_hi = 8'd0;
        count_lo = 8'd5;
        count_en = 1'b1;
        sink_space = LW'(1000);
        for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 8; c++) begin
                for (int s = 0; s < 2; s++) begin
                    int code, sh, ok;
                    play_en = 1'b0;
                    step();
                    ext_mode = e[0];
                    fmt_byte = {c[2:0], s[0], 4'h0};
                    play_en = 1'b1;
                    step();
                    code = (e != 0) ? c : (c & 3);
                    ok = 1;
                    if (code == 0 || code == 1 || code == 3) sh = s;
                    else if (code == 2 || code == 6) sh = 1 + s;
                    else begin sh = 0; ok = 0; end
                    chk(ok ? "R2 active" : "R9 fault active", int'(play_active), ok);
                    chk(ok ? "R2 limit" : "R9 fault limit", int'(chunk_limit), ok ? (5 << sh) : 0);
                end
            end
        end

        // Upper count byte: mono 8-bit, count 256
        ext_mode = 1'b0;
        fmt_byte = 8'h00;
        count_hi = 8'd1;
        count_lo = 8'd0;
        restart();
        chk("R3 upper byte", int'(chunk_limit), 256);

        // 16-bit stereo, count 16 -> target 64
        fmt_byte = 8'h50;
        count_hi = 8'd0;
        count_lo = 8'd16;
        sink_space = LW'(100);
        restart();
        chk("R3 target", int'(chunk_limit), 64);
        sink_space = LW'(20);
        step();
        chk("R3 sink smaller", int'(chunk_limit), 20);
        sink_space = LW'(100);
        send(10);
        chk("R6 accumulate", int'(chunk_limit), 54);
        send(0);
        chk("R7 zero len", int'(chunk_limit), 54);
        chk("R10 no flag yet", int'(irq_status), 0);
        send(54);
        chk("R5 int set", int'(irq_status), 1);
        chk("R5 pb set", int'(pb_irq_flag), 1);
        chk("R5 total cleared", int'(chunk_limit), 64);
        send(5);
        chk("R10 sticky", int'(irq_status), 1);
        chk("R6 after fire", int'(chunk_limit), 59);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R10 clear int", int'(irq_status), 0);
        chk("R10 clear pb", int'(pb_irq_flag), 0);

        // Counting disabled: limit = sink, still accumulates
        count_en = 1'b0;
        step();
        chk("R4 unlimited", int'(chunk_limit), 100);
        send(30);
        count_en = 1'b1;
        step();
        chk("R6 accum while disabled", int'(chunk_limit), 29);
        count_en = 1'b0;
        send(40);
        count_en = 1'b1;
        step();
        chk("R7 negative limit", int'(chunk_limit), 0);
        send(3);
        chk("R7 no flag", int'(irq_status), 0);
        count_lo = 8'd32;
        step();
        chk("R7 total unchanged", int'(chunk_limit), 128 - 75);

        // Restart clears
        restart();
        chk("R8 restart clears", int'(chunk_limit), 100);
        sink_space = LW'(200);
        step();
        chk("R8 full target", int'(chunk_limit), 128);

        // Set wins over clear
        chunk_valid = 1'b1;
        chunk_len = LW'(128);
        flag_clr = 1'b1;
        step();
        chunk_valid = 1'b0;
        flag_clr = 1'b0;
        chk("R10 set wins", int'(irq_status), 1);
        chk("R10 set wins pb", int'(pb_irq_flag), 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;

        // Fault mid-run ignores chunks
        ext_mode = 1'b1;
        fmt_byte = 8'hA0;
        step();
        chk("R9 fault active", int'(play_active), 0);
        chk("R9 fault limit", int'(chunk_limit), 0);
        send(128);
        chk("R9 chunk ignored", int'(irq_status), 0);
        fmt_byte = 8'h40;
        step();
        chk("R9 stays faulted", int'(play_active), 0);
        restart();
        chk("R9 recover", int'(play_active), 1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule